// File: doc/BRIEF.md
# Dual-Output Configurable Interrupt Controller

This block collects a large set of interrupt inputs and steers each one to one of two interrupt outputs. Every input has four configuration bits: trigger type (edge or level), polarity, output routing and enable. Inputs first pass through a two-flop synchroniser. Edge sources latch a pending bit, which software clears by writing ones. Level sources show pending for as long as the input sits at its active level.

Software reaches the block through a word-addressed register bus with two banks. Bank 0 holds the configuration arrays. Bank 1 holds the clear array, the masked pending status for each output, and a summary word. The summary word shows which 32-bit words hold masked pending sources, so an interrupt handler can find the right status word with one read. The search for the highest pending source is left to software.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Source n maps to word n/32, bit n%32, and the block has NW = ceil(NUM_SRC/32) words. In bank 0 (bus_bank=0), type is at words 0..NW-1, polarity at NW..2NW-1, routing at 2NW..3NW-1 and enable at 3NW..4NW-1. A read returns data on bus_rdata in the cycle after the request. Bits for sources at or above NUM_SRC read as zero.
- R2: After reset, every type bit is 1 (edge), every polarity bit is 0, every routing bit is 1 (output 0), every enable bit is 0, nothing is pending, and both outputs are low.
- R3: Each input goes through two synchronising flops. An edge source (type 1) with polarity 0 latches pending on a rising input, and with polarity 1 on a falling input. The output rises on the fourth clock edge after the input changes.
- R4: An edge pending bit stays set until software writes 1 to its bit in the clear array (bank 1, words 0..NW-1). Zero bits in that write have no effect, and an input held at its active level does not set the bit again.
- R5: A level source (type 0) is pending while its input is active: high for polarity 0, low for polarity 1. Writing the clear array has no lasting effect on it.
- R6: Masked status is pending AND enable AND routing match, where routing 1 selects output 0 (irq_ext0) and routing 0 selects output 1 (irq_ext1). The output-1 status is at bank 1 words NW..2NW-1 and the output-0 status at words 2NW..3NW-1.
- R7: The summary word is at bank 1 word 31. Bit w is set when output-1 status word w is nonzero, and bit 8+w when output-0 status word w is nonzero. All other bits read 0.
- R8: Each output is a registered OR of its masked status words.
- R9: The clear array, unmapped addresses and the summary word all read as zero where no field is defined. Writes to the status and summary words are ignored.
- R10: Changing a polarity bit while the input is steady does not create an edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous interrupt inputs |
| bus_en | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_bank | input | 1 | Bank select (0 = configuration, 1 = clear/status) |
| bus_addr | input | ADDR_W | Word address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| irq_ext0 | output | 1 | Interrupt output 0 |
| irq_ext1 | output | 1 | Interrupt output 1 |

## Verification
The bench builds the block with NUM_SRC=40. That gives two words, the second one partly filled, so every source can be swept one at a time in edge, falling-edge and level modes with both routings in a few thousand cycles. The partial word exposes the zeroing of bits above NUM_SRC. The small address map also places the summary bits of both outputs for more than one word within reach of direct checks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_W = 32;
  localparam int ARR_TYPE  = 0;
  localparam int ARR_POL   = 1;
  localparam int ARR_ROUTE = 2;
  localparam int ARR_MASK  = 3;
  localparam int NUM_ARR   = 4;
  localparam int SUMMARY_WORD = 31;
  localparam int EXT0_SUM_SHIFT = 8;

  function automatic int words_for(input int nsrc);
    return (nsrc + WORD_W - 1) / WORD_W;
  endfunction

  function automatic logic [WORD_W-1:0] valid_bits(input int nsrc, input int widx);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int b = 0; b < WORD_W; b++)
      if (widx * WORD_W + b < nsrc) v[b] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= '0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_word.sv
module irqc_word
  import irqc_pkg::*;
#(
  parameter int WIDX    = 0,
  parameter int NUM_SRC = 224
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] sync_in,
  input  logic [NUM_ARR-1:0] cfg_we,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] type_q,
  output logic [WORD_W-1:0] pol_q,
  output logic [WORD_W-1:0] route_q,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] pend_q,
  output logic [WORD_W-1:0] msk_ext0,
  output logic [WORD_W-1:0] msk_ext1
);
  localparam logic [WORD_W-1:0] VALID = valid_bits(NUM_SRC, WIDX);

  logic [WORD_W-1:0] prev_q;
  logic [WORD_W-1:0] act_now, act_prev, edge_det, clr_bits, pend_d;

  // configuration storage
  always_ff @(posedge clk) begin
    if (rst) begin
      type_q  <= VALID;
      pol_q   <= '0;
      route_q <= VALID;
      mask_q  <= '0;
    end else begin
      if (cfg_we[ARR_TYPE])  type_q  <= wdata & VALID;
      if (cfg_we[ARR_POL])   pol_q   <= wdata & VALID;
      if (cfg_we[ARR_ROUTE]) route_q <= wdata & VALID;
      if (cfg_we[ARR_MASK])  mask_q  <= wdata & VALID;
    end
  end

  // detection: both samples are seen through the current polarity,
  // so a polarity change alone never looks like a transition
  always_comb begin
    act_now  = (sync_in ^ pol_q) & VALID;
    act_prev = (prev_q  ^ pol_q) & VALID;
    edge_det = act_now & ~act_prev;
    clr_bits = clr_we ? wdata : '0;
    pend_d   = (type_q & ((pend_q & ~clr_bits) | edge_det)) |
               (~type_q & act_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_in;
      pend_q <= pend_d & VALID;
    end
  end

  assign msk_ext0 = pend_q & mask_q &  route_q;
  assign msk_ext1 = pend_q & mask_q & ~route_q;

  // R3: a detected transition on an edge source is latched
  a_r3_edge_latches: assert property (@(posedge clk) disable iff (rst)
    ((type_q & edge_det) != '0) |=>
      ((pend_q & $past(type_q & edge_det)) == $past(type_q & edge_det)));

  // R4: cleared edge bits with no new transition go low
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((pend_q & $past(wdata & type_q & ~edge_det)) == '0));

  // R1: bits above NUM_SRC never hold state
  a_r1_invalid_zero: assert property (@(posedge clk) disable iff (rst)
    ((type_q | route_q | mask_q | pol_q | pend_q) & ~VALID) == '0);
endmodule

// File: rtl/irqc_readmux.sv
module irqc_readmux
  import irqc_pkg::*;
#(
  parameter int NW     = 7,
  parameter int ADDR_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic                       bank,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NW-1:0][WORD_W-1:0]  type_w,
  input  logic [NW-1:0][WORD_W-1:0]  pol_w,
  input  logic [NW-1:0][WORD_W-1:0]  route_w,
  input  logic [NW-1:0][WORD_W-1:0]  mask_w,
  input  logic [NW-1:0][WORD_W-1:0]  m0_w,
  input  logic [NW-1:0][WORD_W-1:0]  m1_w,
  output logic [WORD_W-1:0]          rdata
);
  localparam logic [WORD_W-1:0] SUM_USED =
    ((WORD_W'(1) << NW) - 1) | (((WORD_W'(1) << NW) - 1) << EXT0_SUM_SHIFT);

  logic [WORD_W-1:0] summary, rd_d;

  always_comb begin
    summary = '0;
    for (int w = 0; w < NW; w++) begin
      summary[w]                  = |m1_w[w];
      summary[EXT0_SUM_SHIFT + w] = |m0_w[w];
    end
  end

  always_comb begin
    rd_d = '0;
    if (!bank) begin
      for (int w = 0; w < NW; w++) begin
        if (addr == ADDR_W'(ARR_TYPE  * NW + w)) rd_d = type_w[w];
        if (addr == ADDR_W'(ARR_POL   * NW + w)) rd_d = pol_w[w];
        if (addr == ADDR_W'(ARR_ROUTE * NW + w)) rd_d = route_w[w];
        if (addr == ADDR_W'(ARR_MASK  * NW + w)) rd_d = mask_w[w];
      end
    end else begin
      // words 0..NW-1 are the write-only clear array
      for (int w = 0; w < NW; w++) begin
        if (addr == ADDR_W'(NW + w))     rd_d = m1_w[w];
        if (addr == ADDR_W'(2 * NW + w)) rd_d = m0_w[w];
      end
      if (addr == ADDR_W'(SUMMARY_WORD)) rd_d = summary;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_d;
  end

  // R9: the clear array reads back as zero
  a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bank && (addr < ADDR_W'(NW))) |=> (rdata == '0));

  // R7: summary bits outside the two flag fields stay zero
  a_r7_summary_reserved: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bank && (addr == ADDR_W'(SUMMARY_WORD))) |=> ((rdata & ~SUM_USED) == '0));
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 224,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic               bus_bank,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_ext0,
  output logic               irq_ext1
);
  localparam int NW    = words_for(NUM_SRC);
  localparam int PAD_W = NW * WORD_W;

  logic [PAD_W-1:0]            src_pad, src_sync;
  logic [NW-1:0][WORD_W-1:0]   type_w, pol_w, route_w, mask_w, pend_w, m0_w, m1_w;
  logic                        wr_cfg, wr_b1, rd_req;

  assign src_pad = PAD_W'(src_in);
  assign wr_cfg  = bus_en &  bus_we & ~bus_bank;
  assign wr_b1   = bus_en &  bus_we &  bus_bank;
  assign rd_req  = bus_en & ~bus_we;

  irqc_sync #(.W(PAD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (src_pad),
    .sync_out (src_sync)
  );

  generate
    for (genvar w = 0; w < NW; w++) begin : g_word
      logic [NUM_ARR-1:0] cfg_we;
      logic               clr_we;

      for (genvar a = 0; a < NUM_ARR; a++) begin : g_dec
        assign cfg_we[a] = wr_cfg && (bus_addr == ADDR_W'(a * NW + w));
      end
      assign clr_we = wr_b1 && (bus_addr == ADDR_W'(w));

      irqc_word #(.WIDX(w), .NUM_SRC(NUM_SRC)) u_word (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (src_sync[w*WORD_W +: WORD_W]),
        .cfg_we   (cfg_we),
        .clr_we   (clr_we),
        .wdata    (bus_wdata),
        .type_q   (type_w[w]),
        .pol_q    (pol_w[w]),
        .route_q  (route_w[w]),
        .mask_q   (mask_w[w]),
        .pend_q   (pend_w[w]),
        .msk_ext0 (m0_w[w]),
        .msk_ext1 (m1_w[w])
      );
    end
  endgenerate

  irqc_readmux #(.NW(NW), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_req),
    .bank    (bus_bank),
    .addr    (bus_addr),
    .type_w  (type_w),
    .pol_w   (pol_w),
    .route_w (route_w),
    .mask_w  (mask_w),
    .m0_w    (m0_w),
    .m1_w    (m1_w),
    .rdata   (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ext0 <= 1'b0;
      irq_ext1 <= 1'b0;
    end else begin
      irq_ext0 <= |m0_w;
      irq_ext1 <= |m1_w;
    end
  end

  // R2: outputs are low right after reset
  a_r2_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_ext0 && !irq_ext1));

  // R6: with every enable bit clear, neither output can rise
  a_r6_all_masked: assert property (@(posedge clk) disable iff (rst)
    (mask_w == '0) |=> (!irq_ext0 && !irq_ext1));

  // R8: an output only rises when something was pending
  a_r8_needs_pending: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ext0) |-> ($past(pend_w) != '0));
endmodule

// File: tb/dual_irq_ctrl_test.sv
module dual_irq_ctrl_test;
  localparam int NSRC = 40;
  localparam int NW   = 2;
  localparam logic [31:0] V1 = 32'h0000_00FF;

  logic clk = 0;
  logic rst = 1;
  logic [NSRC-1:0] src = '0;
  logic bus_en = 0, bus_we = 0, bus_bank = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq0, irq1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_irq_ctrl #(.NUM_SRC(NSRC)) uut (
    .clk(clk), .rst(rst), .src_in(src),
    .bus_en(bus_en), .bus_we(bus_we), .bus_bank(bus_bank),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ext0(irq0), .irq_ext1(irq1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    for (int i = 0; i < k; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic bank, input int addr, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_bank = bank; bus_addr = 5'(addr); bus_wdata = d;
    cyc(1);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic bank, input int addr, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_bank = bank; bus_addr = 5'(addr);
    cyc(1);
    bus_en = 0;
    d = bus_rdata;
  endtask

  // expected status from a pending model and the configuration model
  logic [63:0] e_pend, e_mask, e_route;

  task automatic chk_status(input string req);
    logic [31:0] d;
    logic [63:0] m0, m1;
    logic [31:0] sum;
    m0 = e_pend & e_mask & e_route;
    m1 = e_pend & e_mask & ~e_route;
    sum = '0;
    for (int w = 0; w < NW; w++) begin
      rd(1, NW + w, d);     chk({req, " R6 ext1 word"}, d, m1[w*32 +: 32]);
      rd(1, 2*NW + w, d);   chk({req, " R6 ext0 word"}, d, m0[w*32 +: 32]);
      sum[w]     = |m1[w*32 +: 32];
      sum[8 + w] = |m0[w*32 +: 32];
    end
    rd(1, 31, d); chk({req, " R7 summary"}, d, sum);
    chk({req, " R8 irq0"}, {31'b0, irq0}, {31'b0, |m0});
    chk({req, " R8 irq1"}, {31'b0, irq1}, {31'b0, |m1});
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cnt);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] rmask;
    e_pend = '0; e_mask = '0; e_route = {24'h0, V1, 32'hFFFF_FFFF};
    cyc(5);
    rst = 0;
    cyc(1);

    // R2 / R1: reset values and layout with partial second word
    chk("R2 irq0 reset", {31'b0, irq0}, 0);
    chk("R2 irq1 reset", {31'b0, irq1}, 0);
    rd(0, 0, d); chk("R2 type w0", d, 32'hFFFF_FFFF);
    rd(0, 1, d); chk("R2 R1 type w1", d, V1);
    rd(0, 2, d); chk("R2 pol w0", d, 0);
    rd(0, 4, d); chk("R2 route w0", d, 32'hFFFF_FFFF);
    rd(0, 5, d); chk("R2 R1 route w1", d, V1);
    rd(0, 6, d); chk("R2 mask w0", d, 0);
    chk_status("R2");

    // R1: write/readback and zeroing above NUM_SRC
    wr(0, 3, 32'hFFFF_FFFF); rd(0, 3, d); chk("R1 pol w1 readback", d, V1);
    wr(0, 3, 0);             rd(0, 3, d); chk("R1 pol w1 cleared", d, 0);
    rd(0, 12, d); chk("R9 unmapped bank0", d, 0);

    // R9: clear array reads zero, status/summary writes ignored
    wr(1, 0, 32'hFFFF_FFFF); rd(1, 0, d); chk("R9 clear reads zero", d, 0);
    wr(1, 31, 32'hFFFF); wr(1, 4, 32'hFFFF_FFFF);
    rd(1, 31, d); chk("R9 summary write ignored", d, 0);
    rd(1, 4, d);  chk("R9 status write ignored", d, 0);

    // enable all, alternate routing: even sources to ext0
    wr(0, 6, 32'hFFFF_FFFF); wr(0, 7, 32'hFFFF_FFFF);
    wr(0, 4, 32'h5555_5555); wr(0, 5, 32'h5555_5555);
    e_mask = {24'h0, V1, 32'hFFFF_FFFF};
    e_route = {24'h0, 32'h55 , 32'h5555_5555};
    chk_status("R6 enabled idle");

    // R3: output latency on source 0
    src[0] = 1;
    cyc(3); chk("R3 irq0 not yet", {31'b0, irq0}, 0);
    cyc(1); chk("R3 irq0 after four edges", {31'b0, irq0}, 1);
    e_pend[0] = 1;
    chk_status("R3 src0");
    wr(1, 0, 32'h1); e_pend[0] = 0; cyc(1);
    chk_status("R4 src0 cleared while held");
    src[0] = 0; cyc(3);

    // R3/R4/R6: rising-edge sweep over every source
    for (int n = 0; n < NSRC; n++) begin
      src[n] = 1; cyc(3);
      e_pend[n] = 1;
      chk_status("R3 rising sweep");
      wr(1, n / 32, 32'hFFFF_FFFF ^ (32'h1 << (n % 32)));
      chk_status("R4 zero bits ignored");
      wr(1, n / 32, 32'h1 << (n % 32)); cyc(1);
      e_pend[n] = 0;
      chk_status("R4 cleared, input held");
      src[n] = 0; cyc(3);
    end

    // R10: polarity change with steady low inputs -> no event
    wr(0, 2, 32'hFFFF_FFFF); wr(0, 3, 32'hFFFF_FFFF); cyc(4);
    chk_status("R10 polarity flip");
    src = '1; cyc(4);
    chk_status("R3 rising ignored when falling selected");
    src[5] = 0; src[33] = 0; cyc(3);
    e_pend[5] = 1; e_pend[33] = 1;
    chk_status("R3 falling edges");
    wr(1, 0, 32'h20); wr(1, 1, 32'h2); cyc(1);
    e_pend[5] = 0; e_pend[33] = 0;
    chk_status("R4 falling cleared");
    wr(0, 2, 0); wr(0, 3, 0); cyc(2);
    src = '0; cyc(4);
    chk_status("R10 back to rising, falling inputs");

    // R5: level sweep
    wr(0, 0, 0); wr(0, 1, 0); cyc(2);
    chk_status("R5 level idle");
    for (int n = 0; n < NSRC; n++) begin
      src[n] = 1; cyc(3);
      e_pend[n] = 1;
      chk_status("R5 level active");
      wr(1, n / 32, 32'h1 << (n % 32)); cyc(1);
      chk_status("R5 clear no lasting effect");
      src[n] = 0; cyc(3);
      e_pend[n] = 0;
      chk_status("R5 level released");
    end

    // R5: active-low level
    wr(0, 3, 32'h0000_0004); cyc(3);
    e_pend[34] = 1;
    chk_status("R5 active-low level");
    wr(0, 3, 0); cyc(3);
    e_pend[34] = 0;

    // R6: masking and rerouting one pending level source
    src[2] = 1; cyc(3);
    wr(0, 6, 32'hFFFF_FFFB); cyc(1);
    e_pend[2] = 1; e_mask[2] = 0;
    chk_status("R6 masked source hidden");
    wr(0, 6, 32'hFFFF_FFFF); cyc(1); e_mask[2] = 1;
    chk_status("R6 unmasked source shown");
    wr(0, 4, 32'h5555_5551); cyc(1); e_route[2] = 0;
    chk_status("R6 rerouted to ext1");
    rmask = e_route;
    rd(0, 4, d); chk("R1 route readback", d, rmask[31:0]);
    src[2] = 0; cyc(3); e_pend[2] = 0;
    chk_status("R8 all quiet");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule